// File: doc/BRIEF.md
# Circular Hardware Return Stack

This block holds return addresses for a small microcontroller core. It has eight entries of 13 bits each, kept in dedicated storage outside program and data memory. When a subroutine call executes or an interrupt branches to its vector, the core pulses `push_i` with the full program counter on `push_data_i`. A plain return, a return with a literal, or a return from interrupt pulses `pop_i`. The whole 13-bit address is saved, so a return restores the complete address without help from any page-select register.

The entry pointer is internal. Software cannot read or write it. The block has no overflow or underflow flags. The storage acts as a ring: a ninth push lands on the slot that the first push used, and a tenth push lands on the second push's slot. A pop on an empty stack still moves the pointer back and returns whatever stale value sits in that slot. `top_o` always shows the slot just below the pointer, so it is valid as soon as the pointer register updates.

If a push and a pop arrive in the same cycle, the current top entry is replaced by the pushed value and the depth does not change. This matches a return that leads straight into a call.

Top module: `ret_stack`

## Requirements
- R1: A push alone stores `push_data_i`, and from the next cycle `top_o` shows that value.
- R2: A pop alone discards the top entry, and from the next cycle `top_o` shows the entry pushed before it (last in, first out).
- R3: Storage is circular. After nine pushes A0..A8 from an empty stack, A8 overwrites A0. Eight pops after those pushes bring `top_o` back to A8.
- R4: A pop with the pointer at zero wraps the pointer to the last slot and exposes the stale entry there. A later push writes to that last slot.
- R5: A push and a pop in the same cycle replace the top entry with `push_data_i` and leave the depth unchanged. A following pop shows the entry that lay beneath the replaced one.
- R6: The active-low asynchronous reset returns the pointer to zero and leaves the stored entries untouched. After reset, `top_o` shows the last slot (index 7).
- R7: All 13 bits pass through unchanged, including the all-ones and all-zeros values.
- R8: With neither strobe active, `top_o` and the pointer hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears the pointer |
| push_i | input | 1 | Store `push_data_i` as the new top entry |
| pop_i | input | 1 | Discard the top entry |
| push_data_i | input | 13 | Return address to save |
| top_o | output | 13 | Current top-of-stack entry |

## Verification
Push and pop are the two operations that can coincide. The bench raises both strobes in one cycle on a stack holding several known entries. It then checks that `top_o` shows the new value in the next cycle and that the following pop exposes the entry from the second-highest slot. The second-highest slot must show up, not the replaced value and not an entry two slots down. Any of those other results would show that the pointer moved or that the write went to the wrong slot.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b10,
    OP_POP  = 2'b01,
    OP_SWAP = 2'b11
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop);
    return stk_op_e'({push, pop});
  endfunction
endpackage

// File: rtl/ret_stack_ptr.sv
module ret_stack_ptr
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  output logic          we_o,
  output logic [PW-1:0] waddr_o,
  output logic [PW-1:0] top_idx_o
);
  logic [PW-1:0] ptr_q, ptr_d;
  logic [PW-1:0] ptr_dec;

  // DEPTH is a power of two, so PW-bit arithmetic wraps modulo DEPTH
  assign ptr_dec = ptr_q - PW'(1);

  always_comb begin
    ptr_d   = ptr_q;
    we_o    = 1'b0;
    waddr_o = ptr_q;
    unique case (op_i)
      OP_PUSH: begin ptr_d = ptr_q + PW'(1); we_o = 1'b1; end
      OP_POP:  ptr_d = ptr_dec;
      OP_SWAP: begin we_o = 1'b1; waddr_o = ptr_dec; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign top_idx_o = ptr_dec;

  AST_PTR_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_POP |=> ptr_q == PW'($past(ptr_q) - PW'(1))); // R2
  AST_PTR_PUSH_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && ptr_q == PW'(DEPTH - 1)) |=> ptr_q == '0); // R3
  AST_PTR_POP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && ptr_q == '0) |=> ptr_q == PW'(DEPTH - 1)); // R4
  AST_PTR_SWAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SWAP |=> $stable(ptr_q)); // R5
  AST_PTR_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_IDLE |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/ret_stack_mem.sv
module ret_stack_mem #(
  parameter int DEPTH = 8,
  parameter int DW    = 13,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [PW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [PW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] slot_q [DEPTH];

  // entries are not reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i == PW'(g)) slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[raddr_i];
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 13,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] top_o
);
  stk_op_e       op;
  logic          we;
  logic [PW-1:0] waddr, top_idx;

  assign op = decode_op(push_i, pop_i);

  ret_stack_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .we_o      (we),
    .waddr_o   (waddr),
    .top_idx_o (top_idx)
  );

  ret_stack_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (push_data_i),
    .raddr_i (top_idx),
    .rdata_o (top_o)
  );

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> top_o == $past(push_data_i)); // R1
  AST_SWAP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> top_o == $past(push_data_i)); // R5
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i && $past(rst_ni)) |=> $stable(top_o)); // R8
endmodule

// File: tb/ret_stack_tb.sv
`timescale 1ns/1ps
module ret_stack_tb;
  localparam int DW = 13;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push = 1'b0, pop = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] top;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ret_stack u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (wdata),
    .top_o       (top)
  );

  // {push, pop, data, expected top, requirement index}
  localparam int NV = 10;
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 1'b0, 13'h0101, 13'h0101, 4'd1},
    {1'b1, 1'b0, 13'h1FFF, 13'h1FFF, 4'd7},
    {1'b1, 1'b0, 13'h0000, 13'h0000, 4'd7},
    {1'b1, 1'b0, 13'h1555, 13'h1555, 4'd1},
    {1'b0, 1'b0, 13'h0ABC, 13'h1555, 4'd8},
    {1'b0, 1'b1, 13'h0000, 13'h0000, 4'd2},
    {1'b1, 1'b1, 13'h0AAA, 13'h0AAA, 4'd5},
    {1'b0, 1'b1, 13'h0000, 13'h1FFF, 4'd5},
    {1'b0, 1'b1, 13'h0000, 13'h0101, 4'd2},
    {1'b0, 1'b0, 13'h1234, 13'h0101, 4'd8}
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: top_o=%h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [DW-1:0] d);
    push = p; pop = q; wdata = d;
    @(negedge clk);
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // table of mixed operations: R1 R2 R5 R7 R8
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][31], VEC[i][30], VEC[i][29:17]);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), top, VEC[i][16:4]);
    end

    // circular overwrite, R3
    do_reset();
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, DW'(13'h0100 + i));
    check("R3 top after nine pushes", top, 13'h0108);
    step(1'b0, 1'b1, '0);
    check("R3 first pop", top, 13'h0107);
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, '0);
    check("R3 wrapped to newest after eight pops", top, 13'h0108);

    // reset: pointer zero, slots kept, R6
    step(1'b1, 1'b0, 13'h0EEE);
    do_reset();
    check("R6 top shows slot 7 after reset", top, 13'h0107);

    // pop on empty wraps, R4
    step(1'b0, 1'b1, '0);
    check("R4 pop on empty exposes slot 6", top, 13'h0106);
    step(1'b1, 1'b0, 13'h0F0F);
    check("R4 push after wrap", top, 13'h0F0F);
    step(1'b0, 1'b1, '0);
    check("R4 pop returns slot 6 again", top, 13'h0106);

    // idle hold, R8
    repeat (3) @(negedge clk);
    check("R8 idle hold", top, 13'h0106);

    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, top_o=%h expected completion", top);
      report();
    end
  end
endmodule